// File: doc/BRIEF.md
# Dual-Mode MD5 / SHA-1 Compression Engine

This block runs the compression function of either MD5 or SHA-1 on one padded 512-bit message block per request. A single round datapath with five 32-bit working registers does one step per clock. The round logic, constant selection and rotation amounts change with the selected algorithm. SHA-1 uses all five working words, while MD5 uses four and keeps the fifth at zero. The message schedule sits in a sixteen-word circular buffer. That buffer is rewritten in place during SHA-1 and only read during MD5.

The caller supplies the block already padded, together with a mode bit and a flag that marks the first block of a message. The engine keeps the chaining value between requests, so a long message is hashed by issuing its blocks one after another with the flag cleared after the first. When the last step is done, the working words are folded into the chaining value. A one-cycle completion pulse then marks that the digest output holds the new result.

Top module: `dual_hash_core`

## Requirements
- R1: `shaModeI`, sampled with an accepted start, selects the algorithm: 1 runs SHA-1 (80 steps), 0 runs MD5 (64 steps).
- R2: Word i of the block is `msgI[511-32*i -: 32]`, with its four message bytes in stream order and the first byte in bits 31:24. SHA-1 uses each word as given (big-endian). MD5 uses it byte-reversed (little-endian).
- R3: In SHA-1 mode `digestO` is the 160-bit digest with its first byte in bits 159:152. In MD5 mode bits 159:32 hold the 128-bit digest with its first byte in bits 159:152, and bits 31:0 are zero.
- R4: With `firstBlockI`=1 the engine starts from the standard initial values of the selected algorithm, so a single padded block produces the standard digest.
- R5: With `firstBlockI`=0 the engine starts from the chaining value that the previous block left, so a message spread over several blocks produces its standard digest.
- R6: `doneO` rises exactly 65 clocks (MD5) or 81 clocks (SHA-1) after the clock edge that accepts the start.
- R7: `doneO` is high for exactly one cycle. `busyO` is high from the edge that accepts a start until the edge that raises `doneO`, and it is low while `doneO` is high.
- R8: A start request raised while `busyO` is high is ignored. The running block's result, its timing and the number of done pulses are unchanged.
- R9: `digestO` changes only on the edge that raises `doneO` and holds its value between done pulses.
- R10: After reset `busyO` and `doneO` are low and `digestO` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startI | input | 1 | Request to compress the block on `msgI`; accepted only when idle |
| shaModeI | input | 1 | 1 selects SHA-1, 0 selects MD5 |
| firstBlockI | input | 1 | 1 starts from the initial values, 0 continues the chaining value |
| msgI | input | 512 | Padded block, sixteen words, word 0 in the top bits |
| busyO | output | 1 | A block is being compressed |
| doneO | output | 1 | One-cycle pulse: the digest has been updated |
| digestO | output | 160 | Current chaining value in digest byte order |

## Verification
On every cycle, the checker confirms that the done pulse is one cycle wide and that it arrives exactly 65 or 81 cycles after the accepted start. It also confirms that busy only rises after a start, that the digest only moves on a done pulse, and that the MD5 result leaves the low word clear. Whether the digest values themselves are correct can only be shown by the bench scenarios. These compare full results against known digests for empty, short and two-block messages in both modes. Together they cover the byte ordering, the round constants, the message index order and the feed-forward addition. The same goes for the chaining across blocks, the return to the initial values when the first-block flag is set, and a start request raised in the middle of a run.

// File: rtl/dual_hash_pkg.sv
package dual_hash_pkg;

  localparam int WORD_W     = 32;
  localparam int MSG_WORDS  = 16;
  localparam int ST_WORDS   = 5;
  localparam int MD5_STEPS  = 64;
  localparam int SHA_STEPS  = 80;
  localparam int STEP_W     = $clog2(SHA_STEPS);
  localparam int IDX_W      = $clog2(MSG_WORDS);
  localparam int DIG_W      = WORD_W * ST_WORDS;
  localparam int BLK_W      = WORD_W * MSG_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STEP_W-1:0] step_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic  load;
    logic  step;
    logic  fold;
    logic  sha;
    logic  first;
    step_t stepIdx;
  } hcStrobe_t;

  typedef enum logic [2:0] {
    FN_CHOOSE = 3'd0,
    FN_PARITY = 3'd1,
    FN_MAJOR  = 3'd2,
    FN_MD5G   = 3'd3,
    FN_MD5I   = 3'd4
  } fnSel_e;

  localparam word_t SHA_IV [ST_WORDS] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                          32'h10325476, 32'hC3D2E1F0};
  localparam word_t MD5_IV [ST_WORDS] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                          32'h10325476, 32'h00000000};

  function automatic word_t rotl(word_t x, logic [4:0] n);
    return (x << n) | (x >> (6'd32 - {1'b0, n}));
  endfunction

  function automatic word_t bswap(word_t x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  // shared nonlinear function, selected per round
  function automatic word_t mixFn(fnSel_e sel, word_t x, word_t y, word_t z);
    case (sel)
      FN_CHOOSE: return (x & y) | (~x & z);
      FN_PARITY: return x ^ y ^ z;
      FN_MAJOR:  return (x & y) | (x & z) | (y & z);
      FN_MD5G:   return (x & z) | (y & ~z);
      default:   return y ^ (x | ~z);
    endcase
  endfunction

  function automatic word_t shaConst(logic [1:0] rnd);
    case (rnd)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction

  function automatic logic [4:0] md5Rot(logic [1:0] rnd, logic [1:0] j);
    logic [19:0] amts;
    case (rnd)
      2'd0:    amts = {5'd22, 5'd17, 5'd12, 5'd7};
      2'd1:    amts = {5'd20, 5'd14, 5'd9,  5'd5};
      2'd2:    amts = {5'd23, 5'd16, 5'd11, 5'd4};
      default: amts = {5'd21, 5'd15, 5'd10, 5'd6};
    endcase
    return amts[5*j +: 5];
  endfunction

  function automatic logic [IDX_W-1:0] md5Word(logic [1:0] rnd, logic [IDX_W-1:0] j);
    case (rnd)
      2'd0:    return j;
      2'd1:    return 4'd1 + j * 4'd5;
      2'd2:    return 4'd5 + j * 4'd3;
      default: return j * 4'd7;
    endcase
  endfunction

  function automatic word_t md5Const(logic [5:0] i);
    case (i)
      6'd0:  return 32'hd76aa478; 6'd1:  return 32'he8c7b756; 6'd2:  return 32'h242070db;
      6'd3:  return 32'hc1bdceee; 6'd4:  return 32'hf57c0faf; 6'd5:  return 32'h4787c62a;
      6'd6:  return 32'ha8304613; 6'd7:  return 32'hfd469501; 6'd8:  return 32'h698098d8;
      6'd9:  return 32'h8b44f7af; 6'd10: return 32'hffff5bb1; 6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122; 6'd13: return 32'hfd987193; 6'd14: return 32'ha679438e;
      6'd15: return 32'h49b40821; 6'd16: return 32'hf61e2562; 6'd17: return 32'hc040b340;
      6'd18: return 32'h265e5a51; 6'd19: return 32'he9b6c7aa; 6'd20: return 32'hd62f105d;
      6'd21: return 32'h02441453; 6'd22: return 32'hd8a1e681; 6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6; 6'd25: return 32'hc33707d6; 6'd26: return 32'hf4d50d87;
      6'd27: return 32'h455a14ed; 6'd28: return 32'ha9e3e905; 6'd29: return 32'hfcefa3f8;
      6'd30: return 32'h676f02d9; 6'd31: return 32'h8d2a4c8a; 6'd32: return 32'hfffa3942;
      6'd33: return 32'h8771f681; 6'd34: return 32'h6d9d6122; 6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44; 6'd37: return 32'h4bdecfa9; 6'd38: return 32'hf6bb4b60;
      6'd39: return 32'hbebfbc70; 6'd40: return 32'h289b7ec6; 6'd41: return 32'heaa127fa;
      6'd42: return 32'hd4ef3085; 6'd43: return 32'h04881d05; 6'd44: return 32'hd9d4d039;
      6'd45: return 32'he6db99e5; 6'd46: return 32'h1fa27cf8; 6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244; 6'd49: return 32'h432aff97; 6'd50: return 32'hab9423a7;
      6'd51: return 32'hfc93a039; 6'd52: return 32'h655b59c3; 6'd53: return 32'h8f0ccc92;
      6'd54: return 32'hffeff47d; 6'd55: return 32'h85845dd1; 6'd56: return 32'h6fa87e4f;
      6'd57: return 32'hfe2ce6e0; 6'd58: return 32'ha3014314; 6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82; 6'd61: return 32'hbd3af235; 6'd62: return 32'h2ad7d2bb;
      default: return 32'heb86d391;
    endcase
  endfunction

endpackage

// File: rtl/dual_hash_ctrl.sv
module dual_hash_ctrl
  import dual_hash_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startI,
  input  logic      shaModeI,
  input  logic      firstBlockI,
  output hcStrobe_t strobeO,
  output logic      busyO,
  output logic      doneO
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FOLD} ctrlState_e;

  localparam step_t LAST_MD5 = step_t'(MD5_STEPS - 1);
  localparam step_t LAST_SHA = step_t'(SHA_STEPS - 1);

  ctrlState_e state;
  step_t      stepCnt;
  logic       shaLat;
  logic       firstLat;
  logic       accept;
  step_t      lastStep;

  assign accept   = (state == S_IDLE) && startI;
  assign lastStep = shaLat ? LAST_SHA : LAST_MD5;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      stepCnt  <= '0;
      shaLat   <= 1'b0;
      firstLat <= 1'b0;
      doneO    <= 1'b0;
    end else begin
      doneO <= 1'b0;
      case (state)
        S_IDLE: if (startI) begin
          state    <= S_RUN;
          stepCnt  <= '0;
          shaLat   <= shaModeI;
          firstLat <= firstBlockI;
        end
        S_RUN: begin
          if (stepCnt == lastStep) state <= S_FOLD;
          else                     stepCnt <= stepCnt + 1'b1;
        end
        default: begin
          state <= S_IDLE;
          doneO <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobeO.load    = accept;
    strobeO.step    = (state == S_RUN);
    strobeO.fold    = (state == S_FOLD);
    strobeO.sha     = (state == S_IDLE) ? shaModeI    : shaLat;
    strobeO.first   = (state == S_IDLE) ? firstBlockI : firstLat;
    strobeO.stepIdx = stepCnt;
  end

  assign busyO = (state != S_IDLE);

endmodule

// File: rtl/dual_hash_datapath.sv
module dual_hash_datapath
  import dual_hash_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hcStrobe_t        strobeI,
  input  logic [BLK_W-1:0] msgI,
  output logic [DIG_W-1:0] digestO
);

  word_t st    [ST_WORDS];
  word_t chain [ST_WORDS];
  word_t sched [MSG_WORDS];
  word_t base  [ST_WORDS];
  logic  outSha;

  step_t            t;
  logic [1:0]       shaRnd;
  logic [1:0]       md5Rnd;
  logic [IDX_W-1:0] slot;
  word_t            wCur;
  word_t            fnOut;
  fnSel_e           fnSel;
  word_t            shaTemp;
  word_t            md5Sum;
  word_t            md5New;

  assign t      = strobeI.stepIdx;
  assign slot   = t[IDX_W-1:0];
  assign md5Rnd = t[5:4];

  always_comb begin
    if      (t < step_t'(20)) shaRnd = 2'd0;
    else if (t < step_t'(40)) shaRnd = 2'd1;
    else if (t < step_t'(60)) shaRnd = 2'd2;
    else                      shaRnd = 2'd3;
  end

  // round function selection, shared between modes
  always_comb begin
    if (strobeI.sha) begin
      case (shaRnd)
        2'd0:    fnSel = FN_CHOOSE;
        2'd2:    fnSel = FN_MAJOR;
        default: fnSel = FN_PARITY;
      endcase
    end else begin
      case (md5Rnd)
        2'd0:    fnSel = FN_CHOOSE;
        2'd1:    fnSel = FN_MD5G;
        2'd2:    fnSel = FN_PARITY;
        default: fnSel = FN_MD5I;
      endcase
    end
  end

  assign fnOut = mixFn(fnSel, st[1], st[2], st[3]);

  // SHA-1 schedule in a circular buffer of sixteen words
  always_comb begin
    if (t < step_t'(MSG_WORDS))
      wCur = sched[slot];
    else
      wCur = rotl(sched[slot + 4'd13] ^ sched[slot + 4'd8] ^
                  sched[slot + 4'd2]  ^ sched[slot], 5'd1);
  end

  assign shaTemp = rotl(st[0], 5'd5) + fnOut + st[4] + wCur + shaConst(shaRnd);
  assign md5Sum  = st[0] + fnOut + sched[md5Word(md5Rnd, slot)] + md5Const(t[5:0]);
  assign md5New  = st[1] + rotl(md5Sum, md5Rot(md5Rnd, slot[1:0]));

  always_comb begin
    for (int i = 0; i < ST_WORDS; i++)
      base[i] = strobeI.first ? (strobeI.sha ? SHA_IV[i] : MD5_IV[i]) : chain[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ST_WORDS; i++) begin
        st[i]    <= '0;
        chain[i] <= '0;
      end
      for (int i = 0; i < MSG_WORDS; i++) sched[i] <= '0;
      outSha <= 1'b0;
    end else if (strobeI.load) begin
      for (int i = 0; i < ST_WORDS - 1; i++) st[i] <= base[i];
      st[ST_WORDS-1] <= strobeI.sha ? base[ST_WORDS-1] : '0;
      for (int i = 0; i < MSG_WORDS; i++) begin
        sched[i] <= strobeI.sha ? msgI[BLK_W-1-WORD_W*i -: WORD_W]
                                : bswap(msgI[BLK_W-1-WORD_W*i -: WORD_W]);
      end
    end else if (strobeI.step) begin
      if (strobeI.sha) begin
        st[0]       <= shaTemp;
        st[1]       <= st[0];
        st[2]       <= rotl(st[1], 5'd30);
        st[3]       <= st[2];
        st[4]       <= st[3];
        sched[slot] <= wCur;
      end else begin
        st[0] <= st[3];
        st[1] <= md5New;
        st[2] <= st[1];
        st[3] <= st[2];
      end
    end else if (strobeI.fold) begin
      for (int i = 0; i < ST_WORDS - 1; i++) chain[i] <= base[i] + st[i];
      chain[ST_WORDS-1] <= strobeI.sha ? base[ST_WORDS-1] + st[ST_WORDS-1] : '0;
      outSha <= strobeI.sha;
    end
  end

  logic [DIG_W-1:0] shaDig;
  logic [DIG_W-1:0] md5Dig;

  for (genvar gi = 0; gi < ST_WORDS; gi++) begin : g_dig
    assign shaDig[DIG_W-1-WORD_W*gi -: WORD_W] = chain[gi];
    if (gi < ST_WORDS - 1) begin : g_md5
      assign md5Dig[DIG_W-1-WORD_W*gi -: WORD_W] = bswap(chain[gi]);
    end else begin : g_pad
      assign md5Dig[DIG_W-1-WORD_W*gi -: WORD_W] = '0;
    end
  end

  assign digestO = outSha ? shaDig : md5Dig;

endmodule

// File: rtl/dual_hash_core.sv
module dual_hash_core
  import dual_hash_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic             shaModeI,
  input  logic             firstBlockI,
  input  logic [BLK_W-1:0] msgI,
  output logic             busyO,
  output logic             doneO,
  output logic [DIG_W-1:0] digestO
);

  hcStrobe_t strobe;

  dual_hash_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startI      (startI),
    .shaModeI    (shaModeI),
    .firstBlockI (firstBlockI),
    .strobeO     (strobe),
    .busyO       (busyO),
    .doneO       (doneO)
  );

  dual_hash_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobeI (strobe),
    .msgI    (msgI),
    .digestO (digestO)
  );

endmodule

// File: rtl/dual_hash_core_chk.sv
module dual_hash_core_chk
  import dual_hash_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             startI,
  input logic             shaModeI,
  input logic             busyO,
  input logic             doneO,
  input logic [DIG_W-1:0] digestO
);

  logic [7:0] latCnt;
  logic       trackSha;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latCnt   <= '0;
      trackSha <= 1'b0;
    end else if (startI && !busyO) begin
      latCnt   <= '0;
      trackSha <= shaModeI;
    end else if (latCnt != 8'hFF) begin
      latCnt <= latCnt + 1'b1;
    end
  end

  // R6
  latency_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> latCnt == (trackSha ? 8'(SHA_STEPS + 1) : 8'(MD5_STEPS + 1)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !busyO);

  // R8
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyO) |-> $past(startI));

  // R9
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneO |-> $stable(digestO));

  // R3
  md5_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !trackSha) |-> digestO[WORD_W-1:0] == '0);

endmodule

bind dual_hash_core dual_hash_core_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startI   (startI),
  .shaModeI (shaModeI),
  .busyO    (busyO),
  .doneO    (doneO),
  .digestO  (digestO)
);

// File: tb/dual_hash_core_tb.sv
module dual_hash_core_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startI = 1'b0;
  logic         shaModeI = 1'b0;
  logic         firstBlockI = 1'b0;
  logic [511:0] msgI = '0;
  logic         busyO;
  logic         doneO;
  logic [159:0] digestO;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_hash_core u_dut (
    .clk(clk), .rstN(rstN), .startI(startI), .shaModeI(shaModeI),
    .firstBlockI(firstBlockI), .msgI(msgI), .busyO(busyO), .doneO(doneO),
    .digestO(digestO)
  );

  // padded blocks, bytes in stream order (R2)
  localparam logic [511:0] BLK_EMPTY = {32'h80000000, 480'h0};
  localparam logic [511:0] BLK_ABC_SHA = {32'h61626380, 448'h0, 32'h00000018};
  localparam logic [511:0] BLK_ABC_MD5 = {32'h61626380, 416'h0, 32'h18000000, 32'h0};
  localparam logic [447:0] LONG_TXT = {
    32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667, 32'h65666768,
    32'h66676869, 32'h6768696a, 32'h68696a6b, 32'h696a6b6c, 32'h6a6b6c6d,
    32'h6b6c6d6e, 32'h6c6d6e6f, 32'h6d6e6f70, 32'h6e6f7071};
  localparam logic [511:0] BLK_LONG1 = {LONG_TXT, 32'h80000000, 32'h0};
  localparam logic [511:0] BLK_LONG2_SHA = {480'h0, 32'h000001c0};
  localparam logic [511:0] BLK_LONG2_MD5 = {448'h0, 32'hc0010000, 32'h0};

  localparam logic [159:0] SHA_ABC   = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
  localparam logic [159:0] SHA_EMPTY = 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709;
  localparam logic [159:0] SHA_LONG  = 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1;
  localparam logic [159:0] MD5_ABC   = {128'h900150983cd24fb0d6963f7d28e17f72, 32'h0};
  localparam logic [159:0] MD5_EMPTY = {128'hd41d8cd98f00b204e9800998ecf8427e, 32'h0};
  localparam logic [159:0] MD5_LONG  = {128'h8215ef0796a20bcaaae116d3876c664a, 32'h0};

  task automatic check(string req, logic [159:0] act, logic [159:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one block, optionally poke a second start at cycle pokeAt; return digest, latency, done count
  task automatic runBlock(input logic sha, input logic first, input logic [511:0] blk,
                          input int pokeAt, output logic [159:0] dig, output int lat,
                          output int doneCnt);
    int cnt;
    @(negedge clk);
    shaModeI = sha; firstBlockI = first; msgI = blk; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    cnt = 1;
    doneCnt = 0;
    check("R7 busy after start", {159'h0, busyO}, 160'h1);
    while (!doneO && cnt < 300) begin
      @(negedge clk);
      cnt++;
      if (cnt == pokeAt) begin
        shaModeI = ~sha; firstBlockI = 1'b1; msgI = BLK_EMPTY; startI = 1'b1;
      end else if (cnt == pokeAt + 1) begin
        startI = 1'b0;
      end
    end
    lat = cnt;
    dig = digestO;
    if (doneO) doneCnt = 1;
    check("R7 busy low at done", {159'h0, busyO}, 160'h0);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (doneO) doneCnt++;
    end
  endtask

  task automatic testReset();
    check("R10 done after reset", {159'h0, doneO}, 160'h0);
    check("R10 busy after reset", {159'h0, busyO}, 160'h0);
    check("R10 digest after reset", digestO, 160'h0);
  endtask

  task automatic testSingle(input logic sha, input logic [511:0] blk, input logic [159:0] exp,
                            string tag);
    logic [159:0] d; int lat; int dc;
    runBlock(sha, 1'b1, blk, -10, d, lat, dc);
    check({"R4 R2 R3 ", tag}, d, exp);
    check({"R6 R1 latency ", tag}, 160'(lat), sha ? 160'd82 : 160'd66);
    check({"R7 one done ", tag}, 160'(dc), 160'd1);
  endtask

  task automatic testTwoBlock(input logic sha, input logic [511:0] b2, input logic [159:0] exp);
    logic [159:0] d; int lat; int dc;
    runBlock(sha, 1'b1, BLK_LONG1, -10, d, lat, dc);
    runBlock(sha, 1'b0, b2, -10, d, lat, dc);
    check(sha ? "R5 sha two-block" : "R5 md5 two-block", d, exp);
  endtask

  task automatic testBusyStart();
    logic [159:0] d; int lat; int dc;
    runBlock(1'b1, 1'b1, BLK_ABC_SHA, 10, d, lat, dc);
    check("R8 result unchanged", d, SHA_ABC);
    check("R8 latency unchanged", 160'(lat), 160'd82);
    check("R8 single done", 160'(dc), 160'd1);
  endtask

  task automatic testHold();
    logic [159:0] d; int lat; int dc;
    runBlock(1'b0, 1'b1, BLK_ABC_MD5, -10, d, lat, dc);
    for (int k = 0; k < 5; k++) @(negedge clk);
    check("R9 digest held", digestO, MD5_ABC);
    check("R9 done low", {159'h0, doneO}, 160'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testSingle(1'b1, BLK_ABC_SHA, SHA_ABC, "sha abc");
    testSingle(1'b0, BLK_ABC_MD5, MD5_ABC, "md5 abc");
    testSingle(1'b1, BLK_EMPTY, SHA_EMPTY, "sha empty");
    testSingle(1'b0, BLK_EMPTY, MD5_EMPTY, "md5 empty");
    testTwoBlock(1'b1, BLK_LONG2_SHA, SHA_LONG);
    testTwoBlock(1'b0, BLK_LONG2_MD5, MD5_LONG);
    // R4: flag set again after a chained message restarts from initial values
    testSingle(1'b0, BLK_ABC_MD5, MD5_ABC, "md5 abc after chain");
    testBusyStart();
    testHold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule